// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block decides when a small 8-bit processor core takes an interrupt. The core runs on a machine cycle of four clocks, and the block counts the four phases of each cycle itself. Six external request lines and two timer overflow strobes feed a bank of pending flags. External lines are sampled once per machine cycle, in the third phase. A timer overflow raised anywhere in a machine cycle is posted in that same third phase. Each external line is either edge or level sensitive.

In the third phase of every machine cycle the block also polls the flags it held before that phase's update. It masks them with per-source and global enables and splits them into a high and a low priority group. A request is accepted only when several conditions hold together: the core says the instruction is in its last machine cycle, no enable or priority register access is in progress, no vector call is already running, and the in-service state allows that level. On acceptance the block pulses a call-start strobe, presents the vector address and holds a busy signal for the four machine cycles of the hardware call.

The block keeps one in-service bit per priority level. Only the dedicated return-from-interrupt pulse clears one of these bits; any other core activity leaves them alone.

Top module: `irqPrioCtl`

## Requirements
- R1: `machinePhase` is 0 (first phase) after reset and advances by one every clock, wrapping from 3 back to 0.
- R2: External lines are sampled on the clock edge that ends phase 2 (the third phase). For an edge-mode line (`extEdge` bit = 1), the flag is set when the sample is 1 and the previous phase-2 sample was 0. For a level-mode line (`extEdge` bit = 0), the flag takes the sampled value.
- R3: A `tmrOvf` pulse on any clock is posted to the timer's flag (source index 6 + timer number) on the next phase-2 edge, and no earlier.
- R4: Polling on a phase-2 edge uses the flags held before that edge. With all conditions met, `callBusy` therefore falls 20 clocks (five machine cycles) after the flag first appears on `pendFlags`.
- R5: A request is accepted only on a phase-2 edge where `lastCycle`=1, `regAccess`=0, `globalEn`=1 and the source's `srcEn` bit is 1. `callStart` is then high for exactly one clock, with `machinePhase`=3.
- R6: After acceptance `callBusy` stays high for 16 clocks (four machine cycles), and no further request is accepted while it is high.
- R7: High-priority requests (`srcHiPrio` bit = 1) win over low ones. Within a level, the lowest source index wins. `vecAddr` = VEC_BASE + index × VEC_STEP, which is 3 + 8 × index by default. Indices 0–5 are the external lines and 6–7 the timers.
- R8: A high request is blocked only while `inSvcHi`=1. A low request is blocked while either `inSvcHi` or `inSvcLo` is 1. A running low-level routine can therefore be preempted by a high request. Acceptance sets the in-service bit of the accepted level.
- R9: A `retiPulse` clears `inSvcHi` if it is set, otherwise `inSvcLo`. No other input clears an in-service bit.
- R10: On acceptance, the flag of an edge-mode external source or of a timer source is cleared. A level-mode flag keeps following its input, so a held level request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extReq | input | 6 | External request lines, active high |
| extEdge | input | 6 | Per-line sensitivity: 1 = edge, 0 = level |
| tmrOvf | input | 2 | Timer overflow strobes |
| srcEn | input | 8 | Per-source enable |
| globalEn | input | 1 | Global interrupt enable |
| srcHiPrio | input | 8 | Per-source priority: 1 = high |
| lastCycle | input | 1 | Core is in the last machine cycle of its instruction |
| regAccess | input | 1 | Core is accessing enable or priority registers |
| retiPulse | input | 1 | Return-from-interrupt event |
| callStart | output | 1 | One-clock strobe: begin the hardware vector call |
| callBusy | output | 1 | Vector call in progress |
| vecAddr | output | 16 | Vector address of the accepted source |
| inSvcHi | output | 1 | High-level routine in service |
| inSvcLo | output | 1 | Low-level routine in service |
| pendFlags | output | 8 | Pending flags, index 0–5 external, 6–7 timers |
| machinePhase | output | 2 | Current machine-cycle phase, 0–3 |

## Verification
The bench uses the default parameters: six external lines, two timers, a four-machine-cycle call, a vector base of 3 and a step of 8. These values keep all eight sources and both priority levels in play. Every vector address can be predicted by hand, and the 20-clock minimum latency is short enough to measure exactly. Both levels run nested, so preemption of a low routine and the blocking of a low request under a high routine occur within a few hundred clocks.

// File: rtl/irqPkg.sv
package irqPkg;
  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic sampleNow;  // phase-2 edge: sample lines, post timers
    logic accept;     // a request is taken on this edge
    logic acceptHi;   // the taken request came from the high group
  } irqStrobe_t;
endpackage

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
#(
  parameter int NUM_EXT = 6,
  parameter int NUM_TMR = 2,
  localparam int NSRC  = NUM_EXT + NUM_TMR,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strobe,
  input  logic [NUM_EXT-1:0] extReq,
  input  logic [NUM_EXT-1:0] extEdge,
  input  logic [NUM_TMR-1:0] tmrOvf,
  input  logic [NSRC-1:0]    srcEn,
  input  logic               globalEn,
  input  logic [NSRC-1:0]    srcHiPrio,
  output logic [NSRC-1:0]    pendFlags,
  output logic               hiValid,
  output logic [IDX_W-1:0]   hiIdx,
  output logic               loValid,
  output logic [IDX_W-1:0]   loIdx
);
  logic [NSRC-1:0]    flags;
  logic [NUM_EXT-1:0] prevSample;
  logic [NUM_TMR-1:0] tmrSeen;
  logic [NSRC-1:0]    liveReq, hiReq, loReq, clrMask;
  logic [IDX_W-1:0]   takenIdx;

  assign liveReq = flags & srcEn & {NSRC{globalEn}};
  assign hiReq   = liveReq & srcHiPrio;
  assign loReq   = liveReq & ~srcHiPrio;

  // Fixed polling order: the lowest index wins within a group
  always_comb begin
    hiValid = |hiReq;
    loValid = |loReq;
    hiIdx   = '0;
    loIdx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hiReq[i]) hiIdx = IDX_W'(i);
      if (loReq[i]) loIdx = IDX_W'(i);
    end
  end

  assign takenIdx = strobe.acceptHi ? hiIdx : loIdx;
  assign clrMask  = strobe.accept ? (NSRC'(1) << takenIdx) : '0;

  // External lines, one generate branch per line
  for (genvar e = 0; e < NUM_EXT; e++) begin : gExt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flags[e]      <= 1'b0;
        prevSample[e] <= 1'b0;
      end else if (strobe.sampleNow) begin
        prevSample[e] <= extReq[e];
        if (extEdge[e]) flags[e] <= (flags[e] & ~clrMask[e]) | (extReq[e] & ~prevSample[e]);
        else            flags[e] <= extReq[e];
      end
    end
  end

  // Timer overflows: held until the next sample edge
  for (genvar t = 0; t < NUM_TMR; t++) begin : gTmr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flags[NUM_EXT+t] <= 1'b0;
        tmrSeen[t]       <= 1'b0;
      end else if (strobe.sampleNow) begin
        flags[NUM_EXT+t] <= (flags[NUM_EXT+t] & ~clrMask[NUM_EXT+t]) | tmrSeen[t] | tmrOvf[t];
        tmrSeen[t]       <= 1'b0;
      end else begin
        tmrSeen[t] <= tmrSeen[t] | tmrOvf[t];
      end
    end
  end

  assign pendFlags = flags;
endmodule

// File: rtl/irqControl.sv
module irqControl
  import irqPkg::*;
#(
  parameter int NSRC     = 8,
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  parameter int CALL_MC  = 4,
  localparam int IDX_W     = $clog2(NSRC),
  localparam int CALL_CLKS = CALL_MC * 4,
  localparam int CNT_W     = $clog2(CALL_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hiValid,
  input  logic [IDX_W-1:0]  hiIdx,
  input  logic              loValid,
  input  logic [IDX_W-1:0]  loIdx,
  input  logic              lastCycle,
  input  logic              regAccess,
  input  logic              retiPulse,
  output irqStrobe_t        strobe,
  output logic              callStart,
  output logic              callBusy,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              inSvcHi,
  output logic              inSvcLo,
  output logic [1:0]        machinePhase
);
  logic [1:0]       phase;
  logic [CNT_W-1:0] busyCnt;
  logic             hiOk, loOk, pollOk;
  logic [IDX_W-1:0] winIdx;

  assign hiOk   = hiValid & ~inSvcHi;
  assign loOk   = loValid & ~inSvcHi & ~inSvcLo;
  assign pollOk = (phase == 2'd2) & lastCycle & ~regAccess & (busyCnt == '0);
  assign winIdx = hiOk ? hiIdx : loIdx;

  always_comb begin
    strobe.sampleNow = (phase == 2'd2);
    strobe.accept    = pollOk & (hiOk | loOk);
    strobe.acceptHi  = hiOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= 2'd0;
      busyCnt   <= '0;
      callStart <= 1'b0;
      vecAddr   <= '0;
      inSvcHi   <= 1'b0;
      inSvcLo   <= 1'b0;
    end else begin
      phase     <= phase + 2'd1;
      callStart <= strobe.accept;
      if (strobe.accept) begin
        busyCnt <= CNT_W'(CALL_CLKS);
        vecAddr <= ADDR_W'(VEC_BASE) + ADDR_W'(winIdx) * ADDR_W'(VEC_STEP);
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - CNT_W'(1);
      end
      // Return clears the top active level; a new acceptance sets its own level
      if (strobe.accept && hiOk) inSvcHi <= 1'b1;
      else if (retiPulse && inSvcHi) inSvcHi <= 1'b0;
      if (strobe.accept && !hiOk) inSvcLo <= 1'b1;
      else if (retiPulse && !inSvcHi) inSvcLo <= 1'b0;
    end
  end

  assign callBusy     = (busyCnt != '0);
  assign machinePhase = phase;
endmodule

// File: rtl/irqPrioCtl.sv
module irqPrioCtl
  import irqPkg::*;
#(
  parameter int NUM_EXT  = 6,
  parameter int NUM_TMR  = 2,
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  parameter int CALL_MC  = 4,
  localparam int NSRC  = NUM_EXT + NUM_TMR,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extReq,
  input  logic [NUM_EXT-1:0] extEdge,
  input  logic [NUM_TMR-1:0] tmrOvf,
  input  logic [NSRC-1:0]    srcEn,
  input  logic               globalEn,
  input  logic [NSRC-1:0]    srcHiPrio,
  input  logic               lastCycle,
  input  logic               regAccess,
  input  logic               retiPulse,
  output logic               callStart,
  output logic               callBusy,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic               inSvcHi,
  output logic               inSvcLo,
  output logic [NSRC-1:0]    pendFlags,
  output logic [1:0]         machinePhase
);
  irqStrobe_t       strobe;
  logic             hiValid, loValid;
  logic [IDX_W-1:0] hiIdx, loIdx;

  irqDatapath #(.NUM_EXT(NUM_EXT), .NUM_TMR(NUM_TMR)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .extReq(extReq), .extEdge(extEdge), .tmrOvf(tmrOvf),
    .srcEn(srcEn), .globalEn(globalEn), .srcHiPrio(srcHiPrio),
    .pendFlags(pendFlags), .hiValid(hiValid), .hiIdx(hiIdx),
    .loValid(loValid), .loIdx(loIdx)
  );

  irqControl #(.NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE),
               .VEC_STEP(VEC_STEP), .CALL_MC(CALL_MC)) uCtl (
    .clk(clk), .rstN(rstN), .hiValid(hiValid), .hiIdx(hiIdx),
    .loValid(loValid), .loIdx(loIdx), .lastCycle(lastCycle),
    .regAccess(regAccess), .retiPulse(retiPulse), .strobe(strobe),
    .callStart(callStart), .callBusy(callBusy), .vecAddr(vecAddr),
    .inSvcHi(inSvcHi), .inSvcLo(inSvcLo), .machinePhase(machinePhase)
  );
endmodule

// File: rtl/irqPrioCtlChecker.sv
module irqPrioCtlChecker (
  input logic       clk,
  input logic       rstN,
  input logic       callStart,
  input logic       callBusy,
  input logic       inSvcHi,
  input logic       inSvcLo,
  input logic       retiPulse,
  input logic       lastCycle,
  input logic       regAccess,
  input logic [1:0] machinePhase
);
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> machinePhase == $past(machinePhase) + 2'd1); // R1
  AST_START_IN_LAST_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    callStart |-> machinePhase == 2'd3); // R5
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && callStart) |-> ($past(lastCycle) && !$past(regAccess))); // R5
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && callStart) |-> !$past(callBusy)); // R6
  AST_BUSY_WITH_START: assert property (@(posedge clk) disable iff (!rstN)
    callStart |-> callBusy); // R6
  AST_INSVC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !callStart && !$past(retiPulse)) |-> $stable({inSvcHi, inSvcLo})); // R9
endmodule

bind irqPrioCtl irqPrioCtlChecker uChk (
  .clk(clk), .rstN(rstN), .callStart(callStart), .callBusy(callBusy),
  .inSvcHi(inSvcHi), .inSvcLo(inSvcLo), .retiPulse(retiPulse),
  .lastCycle(lastCycle), .regAccess(regAccess), .machinePhase(machinePhase)
);

// File: tb/sim_irqPrioCtl.sv
module sim_irqPrioCtl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [5:0] extReq = '0, extEdge = 6'b111111;
  logic [1:0] tmrOvf = '0;
  logic [7:0] srcEn = 8'hFF, srcHiPrio = 8'h00, pendFlags;
  logic globalEn = 1'b1, lastCycle = 1'b1, regAccess = 1'b0, retiPulse = 1'b0;
  logic callStart, callBusy, inSvcHi, inSvcLo;
  logic [15:0] vecAddr;
  logic [1:0] machinePhase;

  int nTests = 0, nFail = 0;
  bit modelOn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqPrioCtl u0 (.*);

  // Behavioural reference model
  int mPhase, mBusy, mVec;
  bit [7:0] mFlag;
  bit [5:0] mPrev;
  bit [1:0] mSeen;
  bit mHi, mLo, mStart;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mBusy = 0; mVec = 0; mFlag = 0; mPrev = 0; mSeen = 0;
      mHi = 0; mLo = 0; mStart = 0;
    end else begin
      bit [7:0] req;
      int hiI, loI, takeI;
      bit acc, accHi;
      req = mFlag & srcEn & {8{globalEn}};
      hiI = -1; loI = -1;
      for (int i = 7; i >= 0; i--) begin
        if (req[i] && srcHiPrio[i]) hiI = i;
        if (req[i] && !srcHiPrio[i]) loI = i;
      end
      acc = 0; accHi = 0; takeI = -1;
      if (mPhase == 2 && lastCycle && !regAccess && mBusy == 0) begin
        if (hiI >= 0 && !mHi) begin acc = 1; accHi = 1; takeI = hiI; end
        else if (loI >= 0 && !mHi && !mLo) begin acc = 1; takeI = loI; end
      end
      mStart = acc;
      if (retiPulse) begin
        if (mHi) mHi = 0; else mLo = 0;
      end
      if (acc) begin
        if (accHi) mHi = 1; else mLo = 1;
        mBusy = 16;
        mVec = 3 + 8 * takeI;
      end else if (mBusy > 0) mBusy--;
      if (mPhase == 2) begin
        for (int i = 0; i < 6; i++) begin
          if (extEdge[i]) mFlag[i] = (mFlag[i] && takeI != i) || (extReq[i] && !mPrev[i]);
          else mFlag[i] = extReq[i];
          mPrev[i] = extReq[i];
        end
        for (int t = 0; t < 2; t++) begin
          mFlag[6+t] = (mFlag[6+t] && takeI != 6 + t) || mSeen[t] || tmrOvf[t];
          mSeen[t] = 0;
        end
      end else mSeen = mSeen | tmrOvf;
      mPhase = (mPhase + 1) % 4;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (modelOn) begin
    check(machinePhase == 2'(mPhase), "R1 phase", machinePhase, mPhase);
    check(pendFlags == mFlag, "R2/R3/R10 flags", pendFlags, mFlag);
    check(callStart == mStart, "R5 callStart", callStart, mStart);
    check(callBusy == (mBusy != 0), "R6 callBusy", callBusy, mBusy != 0);
    check(vecAddr == 16'(mVec), "R7 vecAddr", vecAddr, mVec);
    check({inSvcHi, inSvcLo} == {mHi, mLo}, "R8/R9 inService", {inSvcHi, inSvcLo}, {mHi, mLo});
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reti();
    retiPulse = 1'b1; waitClk(1); retiPulse = 1'b0;
  endtask

  task automatic pulseExt(input int i);
    extReq[i] = 1'b1; waitClk(8); extReq[i] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nTests++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int n;
    bit seenStart;
    waitClk(3);
    rstN = 1'b1;
    modelOn = 1;
    // R1: reset state seen right after release
    check(machinePhase == 2'd0, "R1 reset phase", machinePhase, 0);
    check(!callBusy && !inSvcHi && !inSvcLo && pendFlags == 0, "R9 reset state", pendFlags, 0);
    waitClk(5);

    // R4: minimum latency, flag visible to service start
    extReq[2] = 1'b1;
    do waitClk(1); while (!pendFlags[2]);
    n = 0; seenStart = 0;
    do begin
      waitClk(1); n++;
      if (callStart) seenStart = 1;
    end while (!(seenStart && !callBusy) && n < 100);
    check(n == 20, "R4 latency clocks", n, 20);
    check(vecAddr == 16'd19, "R7 vector idx2", vecAddr, 19);
    extReq[2] = 1'b0;
    waitClk(40);
    check(inSvcLo, "R9 no clear without reti", inSvcLo, 1);
    reti(); waitClk(1);
    check(!inSvcLo, "R9 reti clears low", inSvcLo, 0);

    // R8: low routine preempted by high; low blocked under high
    pulseExt(1); waitClk(30);
    check(inSvcLo, "R8 low in service", inSvcLo, 1);
    srcHiPrio[5] = 1'b1;
    pulseExt(5); waitClk(30);
    check(inSvcHi && vecAddr == 16'd43, "R8 high preempts low", vecAddr, 43);
    pulseExt(0); waitClk(30);
    check(pendFlags[0] && vecAddr == 16'd43, "R8 low blocked", pendFlags[0], 1);
    reti(); waitClk(30);
    check(!inSvcHi && inSvcLo && pendFlags[0], "R9 reti clears high first", inSvcLo, 1);
    reti(); waitClk(30);
    check(vecAddr == 16'd3 && !pendFlags[0], "R10 edge flag cleared on take", vecAddr, 3);
    reti(); waitClk(5);

    // R7: simultaneous low requests, lowest index first
    extReq[4] = 1'b1; extReq[1] = 1'b1; waitClk(8); extReq = '0;
    waitClk(30);
    check(vecAddr == 16'd11, "R7 lowest index first", vecAddr, 11);
    reti(); waitClk(30);
    check(vecAddr == 16'd35, "R7 second source next", vecAddr, 35);
    reti(); waitClk(5);

    // R3: timer overflow at high priority beats external low
    srcHiPrio[6] = 1'b1;
    tmrOvf[0] = 1'b1; extReq[0] = 1'b1; waitClk(1); tmrOvf[0] = 1'b0;
    waitClk(30); extReq[0] = 1'b0;
    check(inSvcHi && vecAddr == 16'd51, "R3 timer taken high", vecAddr, 51);
    reti(); waitClk(30);
    check(vecAddr == 16'd3, "R8 low after high returns", vecAddr, 3);
    reti(); waitClk(5);

    // R5: gating by lastCycle, regAccess and globalEn
    lastCycle = 1'b0; pulseExt(2); waitClk(40);
    check(!inSvcLo && pendFlags[2], "R5 waits for lastCycle", inSvcLo, 0);
    lastCycle = 1'b1; waitClk(30);
    check(inSvcLo, "R5 taken after lastCycle", inSvcLo, 1);
    reti(); waitClk(5);
    regAccess = 1'b1; pulseExt(3); waitClk(40);
    check(!inSvcLo, "R5 regAccess delays", inSvcLo, 0);
    regAccess = 1'b0; waitClk(30); reti(); waitClk(5);
    globalEn = 1'b0; pulseExt(4); waitClk(40);
    check(!inSvcLo, "R5 global disable", inSvcLo, 0);
    globalEn = 1'b1; waitClk(30); reti(); waitClk(5);

    // R10: level source stays pending while held
    extEdge[3] = 1'b0; extReq[3] = 1'b1; waitClk(40);
    check(inSvcLo && pendFlags[3], "R10 level flag kept", pendFlags[3], 1);
    reti(); waitClk(30);
    check(inSvcLo && vecAddr == 16'd27, "R10 level retaken", vecAddr, 27);
    extReq[3] = 1'b0; waitClk(8); reti(); waitClk(20);
    check(pendFlags == 0 && !inSvcLo, "R2 level flag follows input", pendFlags, 0);

    modelOn = 0;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule